// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Hand-Over

This block is a configurable-width general-purpose I/O port (16 pins by default) behind a small register bus. Software sets a direction for each pin, a data value for each pin, and a per-pin flag that gives the pin to an on-chip peripheral. The block drives each pad's output value and output enable, and it samples each pad's input level through a two-stage synchroniser.

A register read is combinational on the address. Reading the data register mixes two sources bit by bit. A pin set as an output returns the value stored in the data register. A pin set as an input returns the synchronised level seen on the pad. When a pin's hand-over flag is set, the peripheral's output value and output enable drive the pad instead of the port's own registers.

Top module: `gpio_altfn_port`

## Requirements
- R1: After reset the data, direction and hand-over registers are all zero. Every pad output enable is then low, every pad output value is low, and all three registers read as 0x0000.
- R2: A write takes effect at the rising clock edge where `reg_wr_en` is high. The register is chosen by `reg_addr`: 0 selects data, 1 selects direction, 2 selects hand-over. Address 3 reads 0x0000, and a write to it changes no register.
- R3: For a pin whose hand-over bit is 0, a direction bit of 0 holds `pad_oe` low (high-impedance input) and a direction bit of 1 drives `pad_oe` high. In both cases `pad_out` carries the data register bit.
- R4: A write to the data register stores the value for input pins without driving them. The stored value appears on the pad once the pin's direction bit is set.
- R5: In a data-register read, an input pin returns its pad level. A change on `pad_in` shows in `reg_rdata` after exactly two rising edges.
- R6: In a data-register read, an output pin returns the data register bit and not the pad level.
- R7: For a pin whose hand-over bit is 1, `pad_out` equals `per_out` and `pad_oe` equals `per_oe` for that pin.
- R8: Reads of the direction register and the hand-over register return the stored values in the same cycle that the address is applied.
- R9: The choice between pad level and stored bit in a data read follows the direction bit even for pins handed to a peripheral.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 data, 1 direction, 2 hand-over |
| reg_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| pad_in | input | 16 | Level seen on each pad |
| pad_out | output | 16 | Value to drive on each pad |
| pad_oe | output | 16 | Output enable for each pad, 1 drives |
| per_out | input | 16 | Output values from peripherals |
| per_oe | input | 16 | Output enables from peripherals |

## Verification
A register write takes effect at the edge that samples it. `pad_out`, `pad_oe` and the register reads therefore show the new value in the half-cycle after that edge. A change on the pad input reaches a data read only after the second rising edge, and a change on the peripheral inputs reaches the pads in the same cycle. The bench drives inputs on the falling edge and samples shortly after it. A behavioural reference model keeps a two-entry history of the pad level, and the bench compares the design against it on every clock. Directed checks also read the data register after the first edge and after the second edge of a pad change, to confirm that the latency is exactly two edges.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_ALT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int CW = $clog2(STAGES + 1) + 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];

  // counts edges since reset so the latency check only looks at valid history
  logic [CW-1:0] warm_cnt;
  logic          sync_warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_cnt <= '0;
    else if (!sync_warm) warm_cnt <= warm_cnt + 1'b1;
  end
  assign sync_warm = (int'(warm_cnt) >= STAGES);

  generate
    if (STAGES == 2) begin : g_chk2
      AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        sync_warm |-> (dout == $past(din, 2))); // R5
    end
  endgenerate

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] alt_q
);

  logic wr_data, wr_dir, wr_alt;
  assign wr_data = wr_en && (sel == SEL_DATA);
  assign wr_dir  = wr_en && (sel == SEL_DIR);
  assign wr_alt  = wr_en && (sel == SEL_ALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      alt_q  <= '0;
    end else begin
      if (wr_data) data_q <= wdata;
      if (wr_dir)  dir_q  <= wdata;
      if (wr_alt)  alt_q  <= wdata;
    end
  end

  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DATA) |=> (data_q == $past(wdata))); // R2
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DIR) |=> (dir_q == $past(wdata))); // R2
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || sel == SEL_NONE) |=> ($stable(data_q) && $stable(dir_q) && $stable(alt_q))); // R2

endmodule

// File: rtl/gpio_port_pinmux.sv
module gpio_port_pinmux #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] alt_q,
  input  logic [WIDTH-1:0] per_out,
  input  logic [WIDTH-1:0] per_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);

  function automatic logic pick(input logic use_per, input logic per_v, input logic own_v);
    return use_per ? per_v : own_v;
  endfunction

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign pad_out[i] = pick(alt_q[i], per_out[i], data_q[i]);
      assign pad_oe[i]  = pick(alt_q[i], per_oe[i],  dir_q[i]);
    end
  endgenerate

endmodule

// File: rtl/gpio_altfn_port.sv
module gpio_altfn_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [WIDTH-1:0]  reg_wdata,
  output logic [WIDTH-1:0]  reg_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  input  logic [WIDTH-1:0]  per_out,
  input  logic [WIDTH-1:0]  per_oe
);

  reg_sel_e         sel;
  logic [WIDTH-1:0] data_q, dir_q, alt_q, pin_sync;

  assign sel = reg_sel_e'(reg_addr[1:0]);

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .sel(sel), .wdata(reg_wdata),
    .data_q(data_q), .dir_q(dir_q), .alt_q(alt_q)
  );

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_sync)
  );

  gpio_port_pinmux #(.WIDTH(WIDTH)) u_pinmux (
    .data_q(data_q), .dir_q(dir_q), .alt_q(alt_q),
    .per_out(per_out), .per_oe(per_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // output pins return the stored bit, input pins the synchronised level
  function automatic logic [WIDTH-1:0] merge_data(input logic [WIDTH-1:0] dir,
                                                  input logic [WIDTH-1:0] stored,
                                                  input logic [WIDTH-1:0] pins);
    return (dir & stored) | (~dir & pins);
  endfunction

  always_comb begin
    unique case (sel)
      SEL_DATA: reg_rdata = merge_data(dir_q, data_q, pin_sync);
      SEL_DIR:  reg_rdata = dir_q;
      SEL_ALT:  reg_rdata = alt_q;
      default:  reg_rdata = '0;
    endcase
  end

  AST_ALT_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_oe ^ per_oe) | (pad_out ^ per_out)) & alt_q) == '0); // R7
  AST_INPUT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~alt_q & ~dir_q) == '0); // R3
  AST_READ_OUTPUT_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_DATA) |-> (((reg_rdata ^ data_q) & dir_q) == '0)); // R6
  AST_UNUSED_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (reg_rdata == '0)); // R2

endmodule

// File: tb/gpio_altfn_port_bench.sv
module gpio_altfn_port_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   reg_addr = '0;
  logic         reg_wr_en = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_out, pad_oe;
  logic [W-1:0] per_out = '0;
  logic [W-1:0] per_oe = '0;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  gpio_altfn_port u_gpio_altfn_port (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .per_out(per_out), .per_oe(per_oe)
  );

  // behavioural reference model
  logic [W-1:0] m_data, m_dir, m_alt;
  logic [W-1:0] pin_hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = '0; m_dir = '0; m_alt = '0;
      pin_hist = {};
      pin_hist.push_front('0);
      pin_hist.push_front('0);
    end else begin
      if (reg_wr_en) begin
        if (reg_addr == 2'd0) m_data = reg_wdata;
        else if (reg_addr == 2'd1) m_dir = reg_wdata;
        else if (reg_addr == 2'd2) m_alt = reg_wdata;
      end
      pin_hist.push_front(pad_in);
      void'(pin_hist.pop_back());
    end
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      logic [W-1:0] e_out, e_oe, e_rd, seen;
      seen = pin_hist[1];
      e_out = 0; e_oe = 0;
      for (int i = 0; i < W; i++) begin
        e_out[i] = m_alt[i] ? per_out[i] : m_data[i];
        e_oe[i]  = m_alt[i] ? per_oe[i]  : m_dir[i];
      end
      case (reg_addr)
        2'd0: begin
          e_rd = 0;
          for (int i = 0; i < W; i++) e_rd[i] = m_dir[i] ? m_data[i] : seen[i];
        end
        2'd1: e_rd = m_dir;
        2'd2: e_rd = m_alt;
        default: e_rd = 0;
      endcase
      check("R3/R7 model pad_out", pad_out, e_out);
      check("R3/R7 model pad_oe", pad_oe, e_oe);
      check("R5/R6/R8 model read", reg_rdata, e_rd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [W-1:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  initial begin : watchdog
    while (cycles < 5000 && !done) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_check("R1 data reset", 2'd0, 16'h0000);
    rd_check("R1 dir reset", 2'd1, 16'h0000);
    rd_check("R1 alt reset", 2'd2, 16'h0000);
    check("R1 pad_oe reset", pad_oe, 16'h0000);
    check("R1 pad_out reset", pad_out, 16'h0000);

    // R3 direction and drive
    wr(2'd1, 16'h00FF);
    wr(2'd0, 16'hA5C3);
    #1;
    check("R3 pad_oe follows dir", pad_oe, 16'h00FF);
    check("R3 pad_out carries data", pad_out, 16'hA5C3);
    rd_check("R6 output pins read stored bits", 2'd0, 16'h00C3);

    // R5 two-edge input latency
    pad_in = 16'h3C00;
    @(negedge clk); #1;
    check("R5 one edge: not yet visible", reg_rdata, 16'h00C3);
    @(negedge clk); #1;
    check("R5 two edges: visible", reg_rdata, 16'h3CC3);

    // R4 write to inputs stores without driving
    wr(2'd0, 16'h5AC3);
    #1;
    check("R4 input pins not driven", pad_oe, 16'h00FF);
    rd_check("R4 input pins read pad level", 2'd0, 16'h3CC3);
    wr(2'd1, 16'hFFFF);
    #1;
    check("R4 stored value now driven", pad_out, 16'h5AC3);
    check("R4 all pins enabled", pad_oe, 16'hFFFF);
    rd_check("R6 all outputs read stored", 2'd0, 16'h5AC3);

    // R2 unused address
    wr(2'd3, 16'h1234);
    rd_check("R2 addr3 reads zero", 2'd3, 16'h0000);
    rd_check("R2 dir untouched by addr3", 2'd1, 16'hFFFF);
    rd_check("R2 data untouched by addr3", 2'd0, 16'h5AC3);
    rd_check("R2 alt untouched by addr3", 2'd2, 16'h0000);

    // R7 peripheral hand-over
    per_out = 16'hF0F0; per_oe = 16'h00FF;
    wr(2'd2, 16'h0F0F);
    #1;
    check("R7 pad_out mix", pad_out, 16'h50C0);
    check("R7 pad_oe mix", pad_oe, 16'hF0FF);
    rd_check("R8 alt readback", 2'd2, 16'h0F0F);
    rd_check("R8 dir readback", 2'd1, 16'hFFFF);

    // R9 data read follows direction even with hand-over
    wr(2'd1, 16'h0000);
    #1;
    check("R9 pad_oe after dir clear", pad_oe, 16'h000F);
    rd_check("R9 read returns pad level", 2'd0, 16'h3C00);
    per_oe = 16'hFFFF; per_out = 16'h0F0F;
    #1;
    check("R7 peripheral change same cycle oe", pad_oe, 16'h0F0F);
    check("R7 peripheral change same cycle out", pad_out, 16'h0F0F | (16'h5AC3 & 16'hF0F0));

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule